// File: doc/BRIEF.md
# Gamma Correction Table Port

This block holds per-component 8-bit correction tables for three display channels, and it performs the pixel-side lookup that uses them. Software fills the tables through two write-only registers. One register carries a table pointer and a streaming flag. The other carries a table entry. When the streaming flag is set, software can write a long run of entries back to back without reprogramming the pointer.

The tables sit in one flat entry space. Channel `c` starts at entry `c*768`. Inside each channel there are 256 red entries, then 256 green entries, then 256 blue entries. On the pixel side a request names a channel and carries an R, G, B triple. One cycle later the block returns the three corrected values together. If the channel's correction enable is clear, the block returns the inputs unchanged.

When every enable is clear at once, the table storage is treated as powered down. Its contents are lost, so software must reload the tables after turning correction back on.

Top module: `gamma_lut_port`

## Requirements
- R1: A register write with `cfg_sel`=0 loads the table pointer from `cfg_wdata[11:0]` and the streaming flag from `cfg_wdata[15]`. The next data write (`cfg_sel`=1, entry in `cfg_wdata[7:0]`) stores to that pointer.
- R2: With the streaming flag set, each data write stores its entry and then advances the pointer by one.
- R3: With the streaming flag clear, data writes leave the pointer unchanged, so repeated writes overwrite the same entry and its neighbours keep their values.
- R4: The pointer wraps from the last entry (2303) to 0. A data write while the pointer holds a value of 2304 or more is dropped, and if streaming is on the pointer then moves to 0.
- R5: Entry `c*768 + k*256 + i`, with k=0 red, k=1 green and k=2 blue, is the value returned for component k of channel c when the input value is i.
- R6: A request with `pix_valid` high produces `out_valid` high exactly one cycle later, with all three corrected components. `out_valid` is low in every cycle that does not follow a request.
- R7: If `gamma_en[c]` is clear when the request is presented, or if the channel index is 3, the outputs equal the request inputs.
- R8: A lookup presented in the same cycle as a data write to the entry it reads returns the entry's previous value. The next lookup returns the new value.
- R9: While all `gamma_en` bits are clear, every entry reads as 0 and data writes are discarded, although the pointer still advances. While at least one bit is set, clearing and setting other channels' enables leaves the contents intact.
- R10: After reset, `out_valid` and all outputs are 0, the pointer is 0 with streaming off, and every entry reads as 0 until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the pointer register, 1 selects the data register |
| cfg_wdata | input | 16 | Register write value |
| gamma_en | input | 3 | Per-channel correction enable |
| pix_valid | input | 1 | Lookup request |
| pix_ch | input | 2 | Channel of the request |
| pix_r | input | 8 | Red input |
| pix_g | input | 8 | Green input |
| pix_b | input | 8 | Blue input |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_r | output | 8 | Corrected red |
| out_g | output | 8 | Corrected green |
| out_b | output | 8 | Corrected blue |

## Verification
The bench streams the whole table space from pointer 0. The next write then lands back at entry 0, which catches a pointer that stops, or wraps at one channel's size, at the end of the space. A write and a lookup of the same entry are issued in the same cycle. A write-first memory would return the new value there instead of the old one. Writes are also sent from an out-of-range pointer and from a non-streaming pointer, where a faulty decoder would corrupt a real entry or step the pointer. The bench drops every enable and then checks that the tables read as zero. It also checks that turning one channel off and on keeps the tables intact. A design that retained data through power-down, or cleared it on a single-channel change, is caught by one of these two checks.

// File: rtl/gamma_port_pkg.sv
package gamma_port_pkg;
  localparam int GP_NUM_CH   = 3;
  localparam int GP_PIX_W    = 8;
  localparam int GP_NUM_COMP = 3;
  localparam int GP_CFG_W    = 16;

  typedef enum logic {
    REG_PTR  = 1'b0,
    REG_DATA = 1'b1
  } cfg_reg_e;
endpackage

// File: rtl/gamma_ptr_ctrl.sv
module gamma_ptr_ctrl
  import gamma_port_pkg::*;
#(
  parameter int NUM_CH   = GP_NUM_CH,
  parameter int PIX_W    = GP_PIX_W,
  parameter int NUM_COMP = GP_NUM_COMP,
  parameter int CFG_W    = GP_CFG_W,
  parameter int RAM_AW   = $clog2(NUM_CH * (1 << PIX_W))
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic                cfg_sel,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [NUM_COMP-1:0] wr_en,
  output logic [RAM_AW-1:0]   wr_addr,
  output logic [PIX_W-1:0]    wr_data
);
  localparam int ENTRIES = 1 << PIX_W;
  localparam int TOTAL   = NUM_CH * NUM_COMP * ENTRIES;
  localparam int ADDR_W  = $clog2(TOTAL);
  localparam int BLK_W   = ADDR_W - PIX_W;

  logic [ADDR_W-1:0] ptr_q;
  logic              stream_q;
  logic              ptr_wr, data_wr, in_range;
  logic [BLK_W-1:0]  blk, ch_dec, comp_dec;
  logic [PIX_W-1:0]  idx;

  assign ptr_wr   = cfg_we && (cfg_sel == REG_PTR);
  assign data_wr  = cfg_we && (cfg_sel == REG_DATA);
  assign in_range = ptr_q < ADDR_W'(TOTAL);

  // Pointer register: loaded by the pointer register, stepped by data writes
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= '0;
      stream_q <= 1'b0;
    end else if (ptr_wr) begin
      ptr_q    <= cfg_wdata[ADDR_W-1:0];
      stream_q <= cfg_wdata[CFG_W-1];
    end else if (data_wr && stream_q) begin
      if (ptr_q >= ADDR_W'(TOTAL - 1)) ptr_q <= '0;
      else                             ptr_q <= ptr_q + 1'b1;
    end
  end

  // Flat pointer -> (channel, component, index)
  assign blk      = ptr_q[ADDR_W-1:PIX_W];
  assign idx      = ptr_q[PIX_W-1:0];
  assign ch_dec   = blk / BLK_W'(NUM_COMP);
  assign comp_dec = blk - BLK_W'(ch_dec * BLK_W'(NUM_COMP));

  assign wr_addr = RAM_AW'(int'(ch_dec) * ENTRIES + int'(idx));
  assign wr_data = cfg_wdata[PIX_W-1:0];

  for (genvar k = 0; k < NUM_COMP; k++) begin : g_we
    assign wr_en[k] = data_wr && in_range && (comp_dec == BLK_W'(k));
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    data_wr && stream_q && (ptr_q < ADDR_W'(TOTAL - 1)) |=> ptr_q == $past(ptr_q) + 1'b1); // R2
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    data_wr && !stream_q |=> $stable(ptr_q)); // R3
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    data_wr && stream_q && (ptr_q >= ADDR_W'(TOTAL - 1)) |=> ptr_q == '0); // R4
  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en)); // R5
endmodule

// File: rtl/gamma_comp_ram.sv
module gamma_comp_ram #(
  parameter int DEPTH = 768,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_off,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_q;
  logic [DEPTH-1:0] vld;
  logic          vld_q;

  // Read-first synchronous RAM, no reset, suitable for block RAM
  always_ff @(posedge clk) begin
    if (we && !pwr_off) mem[wa] <= wd;
    mem_q <= mem[ra];
  end

  // Per-entry retention flags, lost whenever the storage is powered down
  always_ff @(posedge clk) begin
    if (rst || pwr_off) begin
      vld <= '0;
    end else if (we) begin
      vld[wa] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= vld[ra];
  end

  assign rd_data = vld_q ? mem_q : '0;

  AST_PWR_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    pwr_off && $past(pwr_off) |=> rd_data == '0); // R9
endmodule

// File: rtl/gamma_lut_port.sv
module gamma_lut_port
  import gamma_port_pkg::*;
#(
  parameter int NUM_CH = GP_NUM_CH,
  parameter int PIX_W  = GP_PIX_W,
  parameter int CFG_W  = GP_CFG_W,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [NUM_CH-1:0] gamma_en,
  input  logic              pix_valid,
  input  logic [CH_W-1:0]   pix_ch,
  input  logic [PIX_W-1:0]  pix_r,
  input  logic [PIX_W-1:0]  pix_g,
  input  logic [PIX_W-1:0]  pix_b,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_r,
  output logic [PIX_W-1:0]  out_g,
  output logic [PIX_W-1:0]  out_b
);
  localparam int NUM_COMP  = GP_NUM_COMP;
  localparam int ENTRIES   = 1 << PIX_W;
  localparam int RAM_DEPTH = NUM_CH * ENTRIES;
  localparam int RAM_AW    = $clog2(RAM_DEPTH);

  logic [NUM_COMP-1:0] wr_en;
  logic [RAM_AW-1:0]   wr_addr;
  logic [PIX_W-1:0]    wr_data;
  logic                pwr_off;
  logic                ch_ok, bypass;

  logic [PIX_W-1:0]  pix_in  [NUM_COMP];
  logic [PIX_W-1:0]  pix_q   [NUM_COMP];
  logic [PIX_W-1:0]  lut_rd  [NUM_COMP];
  logic [PIX_W-1:0]  res     [NUM_COMP];
  logic [RAM_AW-1:0] rd_addr [NUM_COMP];
  logic              pv_q, byp_q;

  assign pix_in[0] = pix_r;
  assign pix_in[1] = pix_g;
  assign pix_in[2] = pix_b;
  assign pwr_off   = ~|gamma_en;
  assign ch_ok     = int'(pix_ch) < NUM_CH;

  gamma_ptr_ctrl #(
    .NUM_CH(NUM_CH), .PIX_W(PIX_W), .NUM_COMP(NUM_COMP),
    .CFG_W(CFG_W), .RAM_AW(RAM_AW)
  ) ptr_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // Per-channel bypass decision, out-of-range channels always bypass
  always_comb begin
    bypass = 1'b1;
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(pix_ch) == c) bypass = ~gamma_en[c];
    end
  end

  for (genvar k = 0; k < NUM_COMP; k++) begin : g_comp
    assign rd_addr[k] = ch_ok ? RAM_AW'(int'(pix_ch) * ENTRIES + int'(pix_in[k]))
                              : RAM_AW'(pix_in[k]);

    gamma_comp_ram #(.DEPTH(RAM_DEPTH), .AW(RAM_AW), .DW(PIX_W)) ram_i (
      .clk(clk), .rst(rst), .pwr_off(pwr_off),
      .we(wr_en[k]), .wa(wr_addr), .wd(wr_data),
      .ra(rd_addr[k]), .rd_data(lut_rd[k])
    );

    always_ff @(posedge clk) begin
      if (rst) pix_q[k] <= '0;
      else     pix_q[k] <= pix_in[k];
    end

    assign res[k] = byp_q ? pix_q[k] : lut_rd[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pv_q  <= 1'b0;
      byp_q <= 1'b1;
    end else begin
      pv_q  <= pix_valid;
      byp_q <= bypass;
    end
  end

  assign out_valid = pv_q;
  assign out_r     = res[0];
  assign out_g     = res[1];
  assign out_b     = res[2];

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> out_valid); // R6
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> !out_valid); // R6
  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
    pix_valid && !ch_ok |=> (out_r == $past(pix_r)) && (out_g == $past(pix_g)) && (out_b == $past(pix_b))); // R7
endmodule

// File: tb/gamma_lut_port_tb_top.sv
module gamma_lut_port_tb_top;
  import gamma_port_pkg::*;

  localparam int NCH   = GP_NUM_CH;
  localparam int ENT   = 1 << GP_PIX_W;
  localparam int TOTAL = NCH * GP_NUM_COMP * ENT;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we, cfg_sel;
  logic [15:0] cfg_wdata;
  logic [2:0]  gamma_en;
  logic        pix_valid;
  logic [1:0]  pix_ch;
  logic [7:0]  pix_r, pix_g, pix_b;
  logic        out_valid;
  logic [7:0]  out_r, out_g, out_b;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  logic [7:0] mem_m [TOTAL];
  bit         vld_m [TOTAL];
  int         ptr_m;
  bit         str_m;

  always #10 clk = ~clk;

  gamma_lut_port dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .gamma_en(gamma_en), .pix_valid(pix_valid), .pix_ch(pix_ch),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual cycles %0d expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [7:0] exp_comp(int ch, int k, logic [7:0] v);
    int e;
    if (ch >= NCH || !gamma_en[ch]) return v;
    e = ch * 3 * ENT + k * ENT + int'(v);
    return vld_m[e] ? mem_m[e] : 8'h00;
  endfunction

  function automatic logic [7:0] fill_val(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (gamma_en == 3'b000) for (int i = 0; i < TOTAL; i++) vld_m[i] = 1'b0;
  endtask

  task automatic set_ptr(int a, bit s);
    cfg_we = 1'b1; cfg_sel = 1'b0;
    cfg_wdata = {s, 3'b000, 12'(a)};
    step();
    cfg_we = 1'b0;
    ptr_m = a; str_m = s;
  endtask

  task automatic model_write(logic [7:0] d, bit en_any);
    if (en_any && ptr_m < TOTAL) begin
      mem_m[ptr_m] = d; vld_m[ptr_m] = 1'b1;
    end
    if (str_m) ptr_m = (ptr_m >= TOTAL - 1) ? 0 : ptr_m + 1;
  endtask

  task automatic wr(logic [7:0] d);
    bit en_any;
    en_any = (gamma_en != 3'b000);
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = {8'h00, d};
    step();
    cfg_we = 1'b0;
    model_write(d, en_any);
  endtask

  task automatic look(string req, int ch, logic [7:0] r, logic [7:0] g, logic [7:0] b);
    logic [24:0] exp;
    exp = {1'b1, exp_comp(ch, 0, r), exp_comp(ch, 1, g), exp_comp(ch, 2, b)};
    pix_valid = 1'b1; pix_ch = 2'(ch); pix_r = r; pix_g = g; pix_b = b;
    step();
    pix_valid = 1'b0;
    check(req, {7'd0, out_valid, out_r, out_g, out_b}, {7'd0, exp});
  endtask

  initial begin
    int seed_init;
    seed_init = $urandom(32'h00C0FFEE);
    rst = 1'b1; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0; gamma_en = 3'b000;
    pix_valid = 1'b0; pix_ch = '0; pix_r = '0; pix_g = '0; pix_b = '0;
    for (int i = 0; i < TOTAL; i++) begin mem_m[i] = 8'h00; vld_m[i] = 1'b0; end
    ptr_m = 0; str_m = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    // R10: reset state
    check("R10 reset outputs", {7'd0, out_valid, out_r, out_g, out_b}, 32'd0);
    gamma_en = 3'b111;
    look("R10 unwritten entries read zero", 0, 8'd5, 8'd9, 8'd200);
    // R6: valid drops when no request
    step();
    check("R6 idle valid", {31'd0, out_valid}, 32'd0);

    // R1 R2 R5: stream the whole space
    set_ptr(0, 1'b1);
    for (int i = 0; i < TOTAL; i++) wr(fill_val(i));
    look("R5 channel 0 layout", 0, 8'd1, 8'd2, 8'd3);
    look("R5 channel 1 layout", 1, 8'd100, 8'd17, 8'd255);
    look("R5 channel 2 layout", 2, 8'd0, 8'd128, 8'd77);
    // R4: pointer wrapped after last entry
    wr(8'h5A);
    look("R4 wrap after full stream", 0, 8'd0, 8'd0, 8'd0);
    set_ptr(TOTAL - 2, 1'b1);
    wr(8'hA0); wr(8'hA1); wr(8'hA2);
    look("R4 last blue entries", 2, 8'd0, 8'd0, 8'd254);
    look("R4 last blue entry", 2, 8'd0, 8'd0, 8'd255);
    look("R4 wrap lands at zero", 0, 8'd0, 8'd1, 8'd1);
    // R4: out-of-range pointer drops, then moves to 0
    set_ptr(4000, 1'b1);
    wr(8'h77); wr(8'h78);
    look("R4 out-of-range write", 0, 8'd0, 8'd2, 8'd3);
    // R1 R3: non-streaming pointer
    set_ptr(3 * ENT + ENT + 9, 1'b0);
    wr(8'h31); wr(8'h32);
    look("R3 overwrite same entry", 1, 8'd0, 8'd9, 8'd0);
    look("R3 neighbour untouched", 1, 8'd0, 8'd10, 8'd0);
    // R7: bypass
    gamma_en = 3'b101;
    look("R7 disabled channel bypass", 1, 8'd12, 8'd34, 8'd56);
    look("R7 channel 3 bypass", 3, 8'd200, 8'd1, 8'd99);
    look("R7 enabled channel lookup", 0, 8'd12, 8'd34, 8'd56);
    // R9: retention while another channel stays enabled
    gamma_en = 3'b111;
    look("R9 retained after channel toggle", 1, 8'd12, 8'd9, 8'd56);
    // R8: same-cycle write and lookup
    set_ptr(2 * 3 * ENT + 40, 1'b1);
    begin
      logic [24:0] exp;
      exp = {1'b1, exp_comp(2, 0, 8'd40), exp_comp(2, 1, 8'd40), exp_comp(2, 2, 8'd40)};
      cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 16'h00EE;
      pix_valid = 1'b1; pix_ch = 2'd2; pix_r = 8'd40; pix_g = 8'd40; pix_b = 8'd40;
      step();
      cfg_we = 1'b0; pix_valid = 1'b0;
      model_write(8'hEE, 1'b1);
      check("R8 collision returns old", {7'd0, out_valid, out_r, out_g, out_b}, {7'd0, exp});
    end
    look("R8 next lookup returns new", 2, 8'd40, 8'd40, 8'd40);
    // R9: power-down loses contents, writes discarded
    gamma_en = 3'b000;
    step(); step();
    set_ptr(100, 1'b1);
    wr(8'h99);
    gamma_en = 3'b001;
    look("R9 cleared after power-down", 0, 8'd100, 8'd5, 8'd6);
    set_ptr(100, 1'b1);
    wr(8'h42);
    look("R9 reload after power-up", 0, 8'd100, 8'd1, 8'd1);

    // Random mix: R2 R5 R7
    gamma_en = 3'b111;
    set_ptr(0, 1'b1);
    for (int i = 0; i < TOTAL; i++) wr(fill_val(i * 3 + 1));
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom_range(0, 5));
      if (op == 0) set_ptr(int'($urandom_range(0, TOTAL - 1)), 1'($urandom_range(0, 1)));
      else if (op == 1) wr(8'($urandom));
      else if (op == 2) gamma_en = 3'($urandom_range(1, 7));
      else look("R5 R7 random lookup", int'($urandom_range(0, 3)),
                8'($urandom), 8'($urandom), 8'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule